// File: doc/BRIEF.md
# Mode-Aware Processor Status Register

This block holds the eight flag bits of a CPU whose two index registers share one width setting, 8 or 16 bits. The stored byte changes from three sources. A stack load replaces the whole byte; it serves pull-status and return-from-interrupt. A mask operation carries an 8-bit immediate and either clears or sets every status bit whose operand bit is 1. The ALU writes individual flags under per-bit enables.

A mode input selects emulation or native operation. Bit 4 of the status byte sets the index width in native mode. In emulation mode the same bit is the break indication, and the index width is held at 8 bits. The block drives one width-select output that covers both index registers. It also returns the byte to be pushed onto the stack. No branch-condition output is derived from bit 4.

Top module: `psr_core`

## Requirements
- R1: While reset is held, and after it is released, the stored status is 0x34 (bit 4 set) until the first update. The narrow-index output is 1.
- R2: `idx_narrow_o` is 1 when `emu_mode_i` is 1 or stored bit 4 is 1. It is 0 only in native mode with bit 4 clear. It follows `emu_mode_i` in the same cycle, with no clock edge.
- R3: A clear operation (`mop_i` = 2'b01) makes the status `status & ~mop_mask_i` at the next rising edge.
- R4: A set operation (`mop_i` = 2'b10) makes the status `status | mop_mask_i` at the next rising edge.
- R5: A stack load (`pull_en_i` = 1) stores `pull_byte_i` at the next rising edge. It takes priority over any mask operation and over ALU writes in the same cycle.
- R6: For each bit i with `alu_we_i[i]` = 1, bit i takes `alu_val_i[i]`, and the other bits hold. ALU writes are ignored in a cycle that has a stack load or a mask operation.
- R7: At every rising edge with `emu_mode_i` = 1, stored bit 4 becomes 1 whatever the source. A clear of bit 4, or a loaded 0 in bit 4, therefore leaves it set. Bit 4 is also still set when native mode is re-entered.
- R8: `push_byte_o` always equals the stored status byte.
- R9: In native mode, with no stack load, `mop_i` of 2'b00 or 2'b11 (no operation) and `alu_we_i` all zero, the status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| emu_mode_i | input | 1 | 1 = emulation mode, 0 = native mode |
| mop_i | input | 2 | Mask operation: 00 none, 01 clear, 10 set, 11 none |
| mop_mask_i | input | 8 | Immediate operand of the mask operation |
| pull_en_i | input | 1 | Load the whole byte from the stack |
| pull_byte_i | input | 8 | Byte popped off the stack |
| alu_we_i | input | 8 | Per-flag ALU write enables |
| alu_val_i | input | 8 | Per-flag ALU write values |
| status_o | output | 8 | Stored status byte |
| push_byte_o | output | 8 | Byte to push onto the stack |
| idx_narrow_o | output | 1 | 1 = both index registers 8 bits, 0 = 16 bits |

## Verification
Status updates (R3 to R7, R9) appear one rising edge after the inputs that cause them. The bench drives each stimulus on a falling edge and compares the stored byte and the push byte at the following falling edge, against a model that is advanced once per cycle. The width-select output (R2) is combinational from the mode input. It is compared a short delay after the drive, within the same cycle. The reset value (R1) is checked once the two-stage reset release has run out.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_W   = 8;
  localparam int unsigned IDX_BIT = 4;

  typedef enum logic [1:0] {
    MOP_NONE = 2'b00,
    MOP_CLR  = 2'b01,
    MOP_SET  = 2'b10,
    MOP_RSVD = 2'b11
  } mop_e;
endpackage

// File: rtl/psr_mask_unit.sv
module psr_mask_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] mask_i,
  input  logic [1:0]   mop_i,
  output logic [W-1:0] res_o,
  output logic         hit_o
);
  import psr_pkg::*;

  mop_e kind;

  always_comb begin
    kind  = mop_e'(mop_i);
    res_o = cur_i;
    hit_o = 1'b0;
    unique case (kind)
      MOP_CLR: begin
        res_o = cur_i & ~mask_i;
        hit_o = 1'b1;
      end
      MOP_SET: begin
        res_o = cur_i | mask_i;
        hit_o = 1'b1;
      end
      default: begin
        res_o = cur_i;
        hit_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/psr_alu_merge.sv
module psr_alu_merge #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] we_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] res_o,
  output logic         hit_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign res_o[b] = we_i[b] ? val_i[b] : cur_i[b];
  end

  assign hit_o = |we_i;
endmodule

// File: rtl/psr_next_sel.sv
module psr_next_sel #(
  parameter int unsigned W   = 8,
  parameter int unsigned IDX = 4
) (
  input  logic [W-1:0] cur_i,
  input  logic         emu_i,
  input  logic         pull_en_i,
  input  logic [W-1:0] pull_byte_i,
  input  logic [W-1:0] mask_res_i,
  input  logic         mask_hit_i,
  input  logic [W-1:0] alu_res_i,
  input  logic         alu_hit_i,
  output logic [W-1:0] nxt_o,
  output logic         en_o
);
  logic [W-1:0] pick;
  logic         src_hit;
  logic         force_need;

  always_comb begin
    if (pull_en_i) begin
      pick    = pull_byte_i;
      src_hit = 1'b1;
    end else if (mask_hit_i) begin
      pick    = mask_res_i;
      src_hit = 1'b1;
    end else if (alu_hit_i) begin
      pick    = alu_res_i;
      src_hit = 1'b1;
    end else begin
      pick    = cur_i;
      src_hit = 1'b0;
    end

    nxt_o = pick;
    if (emu_i) begin
      nxt_o[IDX] = 1'b1;
    end

    force_need = emu_i & ~cur_i[IDX];
    en_o       = src_hit | force_need;
  end
endmodule

// File: rtl/psr_core.sv
module psr_core #(
  parameter int unsigned            W          = psr_pkg::PSR_W,
  parameter int unsigned            IDX        = psr_pkg::IDX_BIT,
  parameter int unsigned            RST_STAGES = 2,
  parameter logic [psr_pkg::PSR_W-1:0] RESET_VAL = 8'h34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         emu_mode_i,
  input  logic [1:0]   mop_i,
  input  logic [W-1:0] mop_mask_i,
  input  logic         pull_en_i,
  input  logic [W-1:0] pull_byte_i,
  input  logic [W-1:0] alu_we_i,
  input  logic [W-1:0] alu_val_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] push_byte_o,
  output logic         idx_narrow_o
);
  localparam logic [W-1:0] RST_WORD = RESET_VAL | (W'(1) << IDX);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  logic [W-1:0] p_q;
  logic [W-1:0] p_d;
  logic         p_en;
  logic [W-1:0] mask_res;
  logic         mask_hit;
  logic [W-1:0] alu_res;
  logic         alu_hit;

  psr_mask_unit #(.W(W)) u_mask (
    .cur_i  (p_q),
    .mask_i (mop_mask_i),
    .mop_i  (mop_i),
    .res_o  (mask_res),
    .hit_o  (mask_hit)
  );

  psr_alu_merge #(.W(W)) u_alu (
    .cur_i (p_q),
    .we_i  (alu_we_i),
    .val_i (alu_val_i),
    .res_o (alu_res),
    .hit_o (alu_hit)
  );

  psr_next_sel #(.W(W), .IDX(IDX)) u_sel (
    .cur_i       (p_q),
    .emu_i       (emu_mode_i),
    .pull_en_i   (pull_en_i),
    .pull_byte_i (pull_byte_i),
    .mask_res_i  (mask_res),
    .mask_hit_i  (mask_hit),
    .alu_res_i   (alu_res),
    .alu_hit_i   (alu_hit),
    .nxt_o       (p_d),
    .en_o        (p_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p_q <= RST_WORD;
    end else if (p_en) begin
      p_q <= p_d;
    end
  end

  assign status_o     = p_q;
  assign push_byte_o  = p_q;
  assign idx_narrow_o = emu_mode_i | p_q[IDX];
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned IDX = 4
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         emu_mode_i,
  input logic [1:0]   mop_i,
  input logic [W-1:0] mop_mask_i,
  input logic         pull_en_i,
  input logic [W-1:0] pull_byte_i,
  input logic [W-1:0] alu_we_i,
  input logic [W-1:0] alu_val_i,
  input logic [W-1:0] status_o,
  input logic         idx_narrow_o
);
  logic quiet_native;
  assign quiet_native = !pull_en_i && !emu_mode_i && (alu_we_i == '0)
                        && (mop_i == 2'b00 || mop_i == 2'b11);

  assert_emu_narrow_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    emu_mode_i |-> idx_narrow_o);

  assert_clear_op_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mop_i == 2'b01 && !pull_en_i && !emu_mode_i)
    |=> status_o == ($past(status_o) & ~$past(mop_mask_i)));

  assert_set_op_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mop_i == 2'b10 && !pull_en_i && !emu_mode_i)
    |=> status_o == ($past(status_o) | $past(mop_mask_i)));

  assert_pull_load_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pull_en_i && !emu_mode_i) |=> status_o == $past(pull_byte_i));

  assert_alu_write_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pull_en_i && !emu_mode_i && (mop_i == 2'b00 || mop_i == 2'b11))
    |=> status_o == (($past(status_o) & ~$past(alu_we_i)) | ($past(alu_val_i) & $past(alu_we_i))));

  assert_emu_force_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    emu_mode_i |=> status_o[IDX]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    quiet_native |=> $stable(status_o));
endmodule

bind psr_core psr_core_chk #(.W(W), .IDX(IDX)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .emu_mode_i   (emu_mode_i),
  .mop_i        (mop_i),
  .mop_mask_i   (mop_mask_i),
  .pull_en_i    (pull_en_i),
  .pull_byte_i  (pull_byte_i),
  .alu_we_i     (alu_we_i),
  .alu_val_i    (alu_val_i),
  .status_o     (status_o),
  .idx_narrow_o (idx_narrow_o)
);

// File: tb/psr_core_test.sv
`timescale 1ns/1ps
module psr_core_test;
  logic       clk;
  logic       rst_n;
  logic       emu;
  logic [1:0] mop;
  logic [7:0] mmask;
  logic       pull;
  logic [7:0] pbyte;
  logic [7:0] we;
  logic [7:0] val;
  logic [7:0] status;
  logic [7:0] push;
  logic       narrow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] exp_p;
  string tag;

  psr_core uut (
    .clk (clk), .rst_n (rst_n), .emu_mode_i (emu), .mop_i (mop),
    .mop_mask_i (mmask), .pull_en_i (pull), .pull_byte_i (pbyte),
    .alu_we_i (we), .alu_val_i (val), .status_o (status),
    .push_byte_o (push), .idx_narrow_o (narrow)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] model(input logic [7:0] p, input logic e,
      input logic [1:0] k, input logic [7:0] m, input logic pl,
      input logic [7:0] pb, input logic [7:0] w, input logic [7:0] v);
    logic [7:0] n;
    if (pl) n = pb;
    else if (k == 2'b01) n = p & ~m;
    else if (k == 2'b10) n = p | m;
    else n = (p & ~w) | (v & w);
    if (e) n[4] = 1'b1;
    return n;
  endfunction

  function automatic string pick_tag(input logic e, input logic [1:0] k,
      input logic pl, input logic [7:0] w);
    if (e) return "R7";
    if (pl) return "R5";
    if (k == 2'b01) return "R3";
    if (k == 2'b10) return "R4";
    if (w != 0) return "R6";
    return "R9";
  endfunction

  task automatic cmp(input string r, input logic [7:0] got, input logic [7:0] ex);
    checks++;
    if (got !== ex) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, got, ex);
    end
  endtask

  // drive at falling edge, check narrow now, status at next falling edge
  task automatic step(input logic e, input logic [1:0] k, input logic [7:0] m,
      input logic pl, input logic [7:0] pb, input logic [7:0] w, input logic [7:0] v);
    emu = e; mop = k; mmask = m; pull = pl; pbyte = pb; we = w; val = v;
    #1;
    cmp("R2", {7'b0, narrow}, {7'b0, e | exp_p[4]});
    tag   = pick_tag(e, k, pl, w);
    exp_p = model(exp_p, e, k, m, pl, pb, w, v);
    @(negedge clk);
    cmp(tag, status, exp_p);
    cmp("R8", push, exp_p);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; emu = 1; mop = 0; mmask = 0; pull = 0; pbyte = 0; we = 0; val = 0;
    repeat (3) @(negedge clk);
    cmp("R1", status, 8'h34);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp("R1", status, 8'h34);
    cmp("R1", {7'b0, narrow}, 8'h01);
    exp_p = 8'h34;

    // directed: native, clear bit 4 -> 16-bit indexes
    step(0, 2'b01, 8'h10, 0, 8'h00, 8'h00, 8'h00);
    cmp("R2", {7'b0, narrow}, 8'h00);
    step(0, 2'b10, 8'hC3, 0, 8'h00, 8'h00, 8'h00);   // R4
    step(0, 2'b11, 8'hFF, 0, 8'h00, 8'h00, 8'h00);   // R9 reserved no-op
    step(0, 2'b00, 8'hFF, 0, 8'h00, 8'h00, 8'h00);   // R9 hold
    // R6 ignored while mask op active
    step(0, 2'b01, 8'h01, 0, 8'h00, 8'hFF, 8'hAA);
    // R5 pull beats op and ALU
    step(0, 2'b10, 8'hFF, 1, 8'h05, 8'hFF, 8'hFF);
    step(0, 2'b00, 8'h00, 0, 8'h00, 8'h0F, 8'h0A);   // R6
    // R7: entering emulation sets bit 4
    step(1, 2'b00, 8'h00, 0, 8'h00, 8'h00, 8'h00);
    step(1, 2'b01, 8'h10, 0, 8'h00, 8'h00, 8'h00);
    step(1, 2'b00, 8'h00, 1, 8'h00, 8'h00, 8'h00);
    cmp("R7", status, 8'h10);
    step(0, 2'b00, 8'h00, 0, 8'h00, 8'h00, 8'h00);   // back to native, still 8-bit
    cmp("R7", {7'b0, narrow}, 8'h01);

    for (int i = 0; i < 3000; i++) begin
      logic       e;
      logic [1:0] k;
      logic       pl;
      logic [7:0] w;
      e  = ($urandom % 4) == 0;
      k  = 2'($urandom);
      if (($urandom % 2) == 0) k = 2'b00;
      pl = ($urandom % 10) == 0;
      w  = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
      step(e, k, 8'($urandom), pl, 8'($urandom), w, 8'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule